// File: doc/BRIEF.md
# Free-Running Timer with Output Compare

A 16-bit up-counter advances once per prescaled period of the system clock. The period is picked from eight powers of two, from divide-by-1 to divide-by-128. Four 16-bit compare registers watch the counter. Each one latches its own sticky match flag when its value equals the count. The counter sets an overflow flag when it wraps from all-ones to zero. It can instead be told to return to zero on a channel-0 match, which sets the length of the count cycle.

The channels are grouped in pairs, and each pair owns one output pin. In toggle mode a match on either channel of the pair inverts the pin. In paired mode the even channel drives the pin high and the odd channel drives it low, so two compare values set both edges of a waveform. The count is also brought out as a port so that capture logic elsewhere can share the same time base. Software programs the block through a small single-cycle write bus and a combinational read port.

Top module: `frt_compare`

## Requirements
- R1: After reset the block is in this state: count 0, timer stopped, every flag 0, both pins 0, every control field 0.
- R2: While running (control bit 0), the count rises by one every 2^S system clocks, where S is control bits 3:1. The first increment lands 2^S clocks after the write that starts the timer.
- R3: While stopped, the count holds and the prescaler divider stays at zero.
- R4: When a tick takes the count from 0xFFFF to 0x0000, overflow flag bit 0 (address 2) sets.
- R5: On a tick where compare register n (address 4+n) equals the current count, flag bit 1+n sets. No flag sets while the timer is stopped.
- R6: With control bit 4 set, a channel-0 match loads 0 in place of the increment. A clear of this kind never sets the overflow flag.
- R7: When control bit 5+p is clear, pin p toggles on a tick where exactly one of channels 2p and 2p+1 matches.
- R8: When control bit 5+p is set, a match on channel 2p+1 drives pin p low and a match on channel 2p drives it high. If both match on the same tick, low wins.
- R9: Flags are sticky. Writing 1 to a flag bit at address 2 clears that bit, and a set in the same cycle wins over the clear.
- R10: A write to address 1 loads the count. That cycle's tick then has no effect on the count, the flags or the pins.
- R11: The read data shows the addressed register: 0 control, 1 count, 2 flags, 3 pin states, 4 to 7 compare registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr |
| count_o | output | 16 | Current timer count |
| cmp_out | output | 2 | Compare output pins, one per channel pair |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_flag | output | 4 | Sticky per-channel match flags |

## Verification
Some properties are checked on every cycle. The count may only hold, step by one or return to zero. A stopped timer freezes its count. Flags stay set until a write-one clears them. The overflow flag rises only as the count reads zero. A pin moves only when one of its pair's match flags is set. Other behaviours can only be shown by the bench's scenarios: the exact prescaled period and the latency of the first tick, the clear-on-match cycle length, the set/reset order in paired mode, and toggle cancellation when two channels match together. The bench covers these with directed cases and with a cycle model driven by random register traffic.

// File: rtl/frt_compare.sv
module frt_compare #(
  parameter int W    = 16,
  parameter int SELW = 3,
  parameter int NCH  = 4,
  parameter int AW   = 3
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [W-1:0]    wdata,
  output logic [W-1:0]    rdata,
  output logic [W-1:0]    count_o,
  output logic [NCH/2-1:0] cmp_out,
  output logic            ovf_flag,
  output logic [NCH-1:0]  cmp_flag
);
  localparam int NP   = NCH / 2;
  localparam int PCW  = (1 << SELW) - 1;
  localparam int CMPB = 4;
  localparam int B_CLR  = SELW + 1;
  localparam int B_PAIR = SELW + 2;
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_CNT  = AW'(1);
  localparam logic [AW-1:0] A_FLG  = AW'(2);
  localparam logic [AW-1:0] A_PIN  = AW'(3);

  logic            run, clr_en;
  logic [SELW-1:0] sel;
  logic [NP-1:0]   pair_en;
  logic [PCW-1:0]  pcnt, lim;
  logic [W-1:0]    cnt;
  logic [NCH-1:0][W-1:0] cmp;
  logic [NCH-1:0]  match;
  logic            tick, wr_ctrl, wr_cnt, wr_flg, clr_hit, ovf_set;

  assign wr_ctrl = wr_en && addr == A_CTRL;
  assign wr_cnt  = wr_en && addr == A_CNT;
  assign wr_flg  = wr_en && addr == A_FLG;
  assign lim     = ~({PCW{1'b1}} << sel);
  assign tick    = run && pcnt >= lim;
  assign clr_hit = clr_en && match[0];
  assign ovf_set = tick && !wr_cnt && cnt == {W{1'b1}} && !clr_hit;
  assign count_o = cnt;

  genvar gi;
  generate
    for (gi = 0; gi < NCH; gi++) begin : g_match
      assign match[gi] = tick && !wr_cnt && cnt == cmp[gi];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      sel     <= '0;
      clr_en  <= 1'b0;
      pair_en <= '0;
    end else if (wr_ctrl) begin
      run     <= wdata[0];
      sel     <= wdata[SELW:1];
      clr_en  <= wdata[B_CLR];
      pair_en <= wdata[B_PAIR +: NP];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            pcnt <= '0;
    else if (!run || tick) pcnt <= '0;
    else                   pcnt <= pcnt + PCW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (wr_cnt)  cnt <= wdata;
    else if (clr_hit) cnt <= '0;
    else if (tick)    cnt <= cnt + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp <= '0;
    else
      for (int i = 0; i < NCH; i++)
        if (wr_en && addr == AW'(CMPB + i)) cmp[i] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
      cmp_flag <= '0;
    end else begin
      ovf_flag <= ovf_set | (ovf_flag & ~(wr_flg & wdata[0]));
      cmp_flag <= match | (cmp_flag & ~({NCH{wr_flg}} & wdata[NCH:1]));
    end
  end

  generate
    for (gi = 0; gi < NP; gi++) begin : g_pin
      logic hit_a, hit_b;
      assign hit_a = match[2*gi];
      assign hit_b = match[2*gi+1];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmp_out[gi] <= 1'b0;
        else if (pair_en[gi]) begin
          if (hit_b)      cmp_out[gi] <= 1'b0;
          else if (hit_a) cmp_out[gi] <= 1'b1;
        end else if (hit_a ^ hit_b) cmp_out[gi] <= ~cmp_out[gi];
      end
    end
  endgenerate

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL: begin
        rdata[0]            = run;
        rdata[SELW:1]       = sel;
        rdata[B_CLR]        = clr_en;
        rdata[B_PAIR +: NP] = pair_en;
      end
      A_CNT: rdata = cnt;
      A_FLG: begin
        rdata[0]     = ovf_flag;
        rdata[NCH:1] = cmp_flag;
      end
      A_PIN: rdata[NP-1:0] = cmp_out;
      default:
        for (int i = 0; i < NCH; i++)
          if (addr == AW'(CMPB + i)) rdata = cmp[i];
    endcase
  end
endmodule

// File: rtl/frt_compare_chk.sv
module frt_compare_chk #(
  parameter int W   = 16,
  parameter int NCH = 4,
  parameter int AW  = 3
)(
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [AW-1:0]   addr,
  input logic [W-1:0]    wdata,
  input logic [W-1:0]    count_o,
  input logic [NCH/2-1:0] cmp_out,
  input logic            ovf_flag,
  input logic [NCH-1:0]  cmp_flag,
  input logic            run
);
  logic cnt_wr, flg_wr;
  assign cnt_wr = wr_en && addr == AW'(1);
  assign flg_wr = wr_en && addr == AW'(2);

  p_stop_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !cnt_wr |=> $stable(count_o));

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr |=> (count_o == $past(count_o) || count_o == $past(count_o) + W'(1) || count_o == '0));

  p_ovf_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> count_o == '0);

  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !(flg_wr && wdata[0]) |=> ovf_flag);

  genvar gi;
  generate
    for (gi = 0; gi < NCH; gi++) begin : g_flag
      p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_flag[gi] && !(flg_wr && wdata[gi+1]) |=> cmp_flag[gi]);
    end
    for (gi = 0; gi < NCH/2; gi++) begin : g_pin
      p_pin_needs_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmp_out[gi]) |-> (cmp_flag[2*gi] || cmp_flag[2*gi+1]));
    end
  endgenerate
endmodule

bind frt_compare frt_compare_chk #(.W(W), .NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .count_o(count_o), .cmp_out(cmp_out), .ovf_flag(ovf_flag),
  .cmp_flag(cmp_flag), .run(run));

// File: tb/frt_compare_test.sv
module frt_compare_test;
  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata, count_o;
  logic [1:0]  cmp_out;
  logic        ovf_flag;
  logic [3:0]  cmp_flag;

  frt_compare uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .count_o(count_o), .cmp_out(cmp_out), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag));

  always #10 clk = ~clk;

  int errs = 0, checks = 0;
  bit done = 1'b0, mon_on = 1'b0;

  logic        m_run, m_clr, m_ovf;
  logic [2:0]  m_sel;
  logic [1:0]  m_pair, m_pin;
  logic [6:0]  m_pc;
  logic [15:0] m_cnt;
  logic [15:0] m_cmp [4];
  logic [3:0]  m_flag;

  function automatic logic [15:0] m_read(logic [2:0] a);
    case (a)
      3'd0: return {9'b0, m_pair, m_clr, m_sel, m_run};
      3'd1: return m_cnt;
      3'd2: return {11'b0, m_flag, m_ovf};
      3'd3: return {14'b0, m_pin};
      default: return m_cmp[a - 3'd4];
    endcase
  endfunction

  always @(posedge clk) begin
    automatic logic tk, wc, wf, hit0;
    automatic logic [3:0] mt;
    automatic logic [6:0] lm;
    if (!rst_n) begin
      m_run <= 0; m_clr <= 0; m_ovf <= 0; m_sel <= 0; m_pair <= 0; m_pin <= 0;
      m_pc <= 0; m_cnt <= 0; m_flag <= 0;
      for (int i = 0; i < 4; i++) m_cmp[i] <= 0;
    end else begin
      lm = 7'((1 << m_sel) - 1);
      tk = m_run && m_pc >= lm;
      wc = wr_en && addr == 3'd1;
      wf = wr_en && addr == 3'd2;
      for (int i = 0; i < 4; i++) mt[i] = tk && !wc && m_cnt == m_cmp[i];
      hit0 = m_clr && mt[0];
      m_pc <= (!m_run || tk) ? 7'd0 : m_pc + 7'd1;
      if (wc) m_cnt <= wdata;
      else if (hit0) m_cnt <= 0;
      else if (tk) m_cnt <= m_cnt + 16'd1;
      m_ovf  <= (tk && !wc && m_cnt == 16'hFFFF && !hit0) | (m_ovf & ~(wf & wdata[0]));
      m_flag <= mt | (m_flag & ~({4{wf}} & wdata[4:1]));
      for (int p = 0; p < 2; p++) begin
        if (m_pair[p]) begin
          if (mt[2*p+1]) m_pin[p] <= 1'b0;
          else if (mt[2*p]) m_pin[p] <= 1'b1;
        end else if (mt[2*p] ^ mt[2*p+1]) m_pin[p] <= ~m_pin[p];
      end
      if (wr_en && addr == 3'd0) begin
        m_run <= wdata[0]; m_sel <= wdata[3:1]; m_clr <= wdata[4]; m_pair <= wdata[6:5];
      end
      if (wr_en && addr >= 3'd4) m_cmp[addr - 3'd4] <= wdata;
    end
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && mon_on && !done) begin
    chk("R2 count vs model", count_o, m_cnt);
    chk("R5 flags vs model", {11'b0, cmp_flag, ovf_flag}, {11'b0, m_flag, m_ovf});
    chk("R7 pins vs model", {14'b0, cmp_out}, {14'b0, m_pin});
    chk("R11 read vs model", rdata, m_read(addr));
  end

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk); #2;
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic waitn(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 count", count_o, 16'h0);
    chk("R1 flags", {11'b0, cmp_flag, ovf_flag}, 16'h0);
    chk("R1 pins", {14'b0, cmp_out}, 16'h0);
    chk("R1 ctrl read", rdata, 16'h0);
    mon_on = 1'b1;

    for (int i = 4; i < 8; i++) wr(3'(i), 16'h1234);
    wr(3'd1, 16'hFFFE);
    wr(3'd0, 16'h0001);
    waitn(1);
    chk("R10 loaded count stepped", count_o, 16'hFFFF);
    waitn(1);
    chk("R4 wrap count", count_o, 16'h0000);
    chk("R4 overflow flag", {15'b0, ovf_flag}, 16'h1);

    wr(3'd0, 16'h0000);
    begin
      automatic logic [15:0] held = count_o;
      waitn(10);
      chk("R3 stopped count holds", count_o, held);
    end
    wr(3'd2, 16'h0001);
    waitn(1);
    chk("R9 overflow cleared", {15'b0, ovf_flag}, 16'h0);

    wr(3'd1, 16'h0000);
    wr(3'd0, 16'h0007);
    waitn(7);
    chk("R2 no step before 8 clocks", count_o, 16'h0000);
    waitn(1);
    chk("R2 first step at 8 clocks", count_o, 16'h0001);
    waitn(8);
    chk("R2 second step", count_o, 16'h0002);

    wr(3'd0, 16'h0000);
    wr(3'd2, 16'h001F);
    wr(3'd1, 16'h0000);
    wr(3'd4, 16'h0003);
    wr(3'd0, 16'h0011);
    waitn(3);
    chk("R5 no flag before match", {12'b0, cmp_flag}, 16'h0);
    waitn(1);
    chk("R6 clear on ch0 match", count_o, 16'h0000);
    chk("R5 ch0 flag", {12'b0, cmp_flag}, 16'h1);
    chk("R6 no overflow on clear", {15'b0, ovf_flag}, 16'h0);
    chk("R7 toggle on ch0 match", {15'b0, cmp_out[0]}, 16'h1);

    wr(3'd0, 16'h0000);
    wr(3'd1, 16'h0000);
    wr(3'd6, 16'h0002);
    wr(3'd7, 16'h0004);
    wr(3'd0, 16'h0041);
    waitn(2);
    chk("R8 pin low before set", {15'b0, cmp_out[1]}, 16'h0);
    waitn(1);
    chk("R8 even channel sets pin", {15'b0, cmp_out[1]}, 16'h1);
    waitn(2);
    chk("R8 odd channel clears pin", {15'b0, cmp_out[1]}, 16'h0);

    wr(3'd0, 16'h0000);
    wr(3'd1, 16'h0010);
    wr(3'd6, 16'h0012);
    wr(3'd7, 16'h0012);
    wr(3'd0, 16'h0001);
    begin
      automatic logic p0 = cmp_out[1];
      waitn(4);
      chk("R7 both match cancels toggle", {15'b0, cmp_out[1]}, {15'b0, p0});
      chk("R5 both flags set", {14'b0, cmp_flag[3:2]}, 16'h3);
    end

    for (int n = 0; n < 4000; n++) begin
      automatic int r = $urandom % 16;
      if (r < 4) wr(3'(4 + $urandom % 4), m_cnt + 16'($urandom % 12));
      else if (r == 4) wr(3'd0, {9'b0, 2'($urandom), 1'($urandom), 3'($urandom % 3), 1'(($urandom % 8) != 0)});
      else if (r == 5) wr(3'd2, 16'($urandom));
      else if (r == 6 && ($urandom % 4) == 0) wr(3'd1, 16'($urandom % 2 == 0 ? 16'hFFF8 + $urandom % 8 : $urandom));
      else begin
        @(negedge clk); #2;
        addr = 3'($urandom % 8);
      end
    end
    waitn(2);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errs++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      summary();
      $finish;
    end
  end
endmodule